// File: doc/BRIEF.md
# Vector Element Word Load Unit

This execution unit carries out a single-word element load into a 128-bit vector register. It takes a decoded 32-bit instruction word together with two 64-bit general register values: a base and an index. It adds them to form a 32-bit effective address and issues one four-byte memory read at the word-aligned address. The returned word goes, in big-endian byte order, into one of the four 32-bit lanes of the destination vector. The other three lanes keep their previous contents, so the unit performs a read-modify-write of the destination register.

Two instruction encodings are recognised. The first addresses 32 vector registers with a 5-bit destination field. The second addresses 128 registers by joining a 2-bit high field and a 5-bit low field. When the instruction's base register field is zero, the unit uses the constant zero as the base and ignores the supplied base value. The memory read port and the vector register read port are requested at the same time and may answer in either order. The write back starts once both have answered. The unit accepts no new instruction while it is busy. It raises a one-cycle completion pulse after the write commits, and a one-cycle illegal pulse for a word that matches neither encoding.

Top module: `vec_word_load_unit`

## Requirements
- R1: In the narrow form, instruction bits [31:26] equal 31 and bits [10:1] equal 71. Bit 0 is ignored. The destination index is {2'b00, bits [25:21]}.
- R2: In the wide form, bits [31:26] equal 4 and bits [10:4] equal 8. Bits [1:0] are ignored. The destination index is {bits [3:2], bits [25:21]} and covers registers 0 to 127.
- R3: When the base field, bits [20:16], is zero, the base operand is zero whatever `base_val` holds. Otherwise the base operand is `base_val`.
- R4: `mem_rd_addr` equals the low 32 bits of base operand plus `index_val`, with bits [1:0] forced to zero. Any carry beyond bit 31 is dropped.
- R5: The target lane is address bits [3:2] of the unaligned sum. Lane 0 occupies vector bits [127:96] and lane 3 occupies bits [31:0].
- R6: `mem_rd_data[8k+7:8k]` holds the byte at address `mem_rd_addr`+k. The byte at the lowest address becomes the most significant byte of the target lane.
- R7: The unit reads the destination register (`vrd_idx` equals the destination) before writing it. The three lanes that are not targeted are written back with the values that were read.
- R8: An accepted word matching neither form raises `illegal` for exactly the next cycle. It makes no memory read and no register read or write, and the unit stays ready.
- R9: `issue_ready` is low and `busy` is high from the acceptance of a legal instruction until the cycle after the `vwr_req`/`vwr_ack` handshake. In that following cycle `done` is high for one cycle.
- R10: The memory request and the register read request are both raised in the cycle after acceptance. Each is held, with its address or index stable, until its own handshake. The two may complete in either order or in the same cycle.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The unit can take an instruction |
| issue_instr | input | 32 | Instruction word, bit 31 is the first instruction bit |
| base_val | input | 64 | Value of the base general register |
| index_val | input | 64 | Value of the index general register |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the write commits |
| illegal | output | 1 | One-cycle pulse for an unrecognised word |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the request; data is valid in the same cycle |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_data | input | 32 | Read data, byte k at address +k in bits [8k+7:8k] |
| vrd_req | output | 1 | Vector register read request |
| vrd_ack | input | 1 | Read data is valid in this cycle |
| vrd_idx | output | 7 | Register to read |
| vrd_data | input | 128 | Register contents |
| vwr_req | output | 1 | Vector register write request |
| vwr_ack | input | 1 | Write taken in this cycle |
| vwr_idx | output | 7 | Register to write |
| vwr_data | output | 128 | Merged vector |

## Verification
The two functions that can fall in the same cycle are the memory read response and the destination register read response. Both requests rise together after acceptance. The bench delays each responder by a chosen number of cycles to produce three cases: memory first, register first, and both handshakes on the same clock edge. In each case the bench records the cycle in which each handshake completed and requires exactly one write back. The merged vector, its index and the timing of the completion pulse must match values that the bench computes from the lane and byte-order rules.

// File: rtl/vwl_pkg.sv
package vwl_pkg;

   // Register index width fixed by the wide encoding (2 + 5 bits)
   localparam int VIDX_W = 7;
   localparam int INSTR_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WRITE = 2'd2
   } vwl_state_t;

   typedef struct packed {
      logic              legal;
      logic              base_zero;
      logic [VIDX_W-1:0] dst;
   } vwl_dec_t;

endpackage

// File: rtl/vwl_decode.sv
module vwl_decode
   import vwl_pkg::*;
#(
   parameter int NARROW_OPC = 31,
   parameter int NARROW_XO  = 71,
   parameter int WIDE_OPC   = 4,
   parameter int WIDE_XO    = 8
) (
   input  logic [INSTR_W-1:0] instr,
   output vwl_dec_t           dec
);

   localparam int OPC_W  = 6;
   localparam int NXO_W  = 10;
   localparam int WXO_W  = 7;
   localparam int FLD_W  = 5;
   localparam int HI_W   = VIDX_W - FLD_W;

   logic [OPC_W-1:0] opc;
   logic [NXO_W-1:0] nxo;
   logic [WXO_W-1:0] wxo;
   logic [FLD_W-1:0] dst_lo;
   logic [HI_W-1:0]  dst_hi;
   logic [FLD_W-1:0] base_fld;
   logic             is_narrow;
   logic             is_wide;
   logic             unused_bits;

   assign opc      = instr[31:26];
   assign dst_lo   = instr[25:21];
   assign base_fld = instr[20:16];
   assign nxo      = instr[10:1];
   assign wxo      = instr[10:4];
   assign dst_hi   = instr[3:2];

   // index field and record/reserved bits do not affect this unit
   assign unused_bits = ^{instr[15:11], instr[0]};

   assign is_narrow = (opc == OPC_W'(NARROW_OPC)) && (nxo == NXO_W'(NARROW_XO));
   assign is_wide   = (opc == OPC_W'(WIDE_OPC))   && (wxo == WXO_W'(WIDE_XO));

   always_comb begin
      dec.legal     = is_narrow || is_wide;
      dec.base_zero = (base_fld == '0);
      if (is_wide) begin
         dec.dst = {dst_hi, dst_lo};
      end else begin
         dec.dst = {{HI_W{1'b0}}, dst_lo};
      end
   end

endmodule

// File: rtl/vwl_agu.sv
module vwl_agu #(
   parameter int GPR_W  = 64,
   parameter int ADDR_W = 32,
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int BOFF_W = $clog2(LANE_W / 8),
   localparam int LSEL_W = $clog2(LANES)
) (
   input  logic [GPR_W-1:0]  base_val,
   input  logic [GPR_W-1:0]  index_val,
   input  logic              base_zero,
   output logic [ADDR_W-1:0] addr_aligned,
   output logic [LSEL_W-1:0] lane
);

   logic [GPR_W-1:0]  base_eff;
   logic [GPR_W-1:0]  sum_full;
   logic [ADDR_W-1:0] ea;
   logic              unused_hi;

   assign base_eff = base_zero ? '0 : base_val;
   assign sum_full = base_eff + index_val;
   assign ea       = sum_full[ADDR_W-1:0];

   generate
      if (GPR_W > ADDR_W) begin : g_trunc
         assign unused_hi = ^sum_full[GPR_W-1:ADDR_W];
      end else begin : g_exact
         assign unused_hi = 1'b0;
      end
   endgenerate

   assign addr_aligned = {ea[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
   assign lane         = ea[BOFF_W+LSEL_W-1:BOFF_W];

endmodule

// File: rtl/vwl_merge.sv
module vwl_merge #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int VEC_W  = LANE_W * LANES,
   localparam int NBYTES = LANE_W / 8,
   localparam int LSEL_W = $clog2(LANES)
) (
   input  logic [VEC_W-1:0]  old_vec,
   input  logic [LANE_W-1:0] bus_word,
   input  logic [LSEL_W-1:0] lane,
   output logic [VEC_W-1:0]  new_vec
);

   logic [LANE_W-1:0] be_word;

   // bus byte k (address +k) becomes the k-th most significant byte
   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign be_word[LANE_W-1-8*b -: 8] = bus_word[8*b +: 8];
      end

      // lane 0 sits at the top of the vector
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam int TOP = VEC_W - 1 - l * LANE_W;
         assign new_vec[TOP -: LANE_W] =
            (lane == LSEL_W'(l)) ? be_word : old_vec[TOP -: LANE_W];
      end
   endgenerate

endmodule

// File: rtl/vwl_ctrl.sv
module vwl_ctrl
   import vwl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int VEC_W  = LANE_W * LANES,
   localparam int LSEL_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   output logic              issue_ready,
   input  vwl_dec_t          dec,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [LSEL_W-1:0] lane_in,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [LANE_W-1:0] mem_rd_data,
   output logic              vrd_req,
   input  logic              vrd_ack,
   output logic [VIDX_W-1:0] vrd_idx,
   input  logic [VEC_W-1:0]  vrd_data,
   output logic              vwr_req,
   input  logic              vwr_ack,
   output logic [VIDX_W-1:0] vwr_idx,
   output logic [LANE_W-1:0] word_q,
   output logic [VEC_W-1:0]  vec_q,
   output logic [LSEL_W-1:0] lane_q
);

   vwl_state_t        state;
   logic [VIDX_W-1:0] dst_q;
   logic [ADDR_W-1:0] addr_q;
   logic              got_mem;
   logic              got_vec;
   logic              illegal_q;
   logic              done_q;
   logic              accept;
   logic              mem_fire;
   logic              vec_fire;
   logic              both_in;

   assign accept   = issue_valid && (state == ST_IDLE);
   assign mem_fire = mem_rd_valid && mem_rd_ready;
   assign vec_fire = vrd_req && vrd_ack;
   assign both_in  = (got_mem || mem_fire) && (got_vec || vec_fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         dst_q     <= '0;
         addr_q    <= '0;
         lane_q    <= '0;
         got_mem   <= 1'b0;
         got_vec   <= 1'b0;
         word_q    <= '0;
         vec_q     <= '0;
         illegal_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         illegal_q <= 1'b0;
         done_q    <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (dec.legal) begin
                     state   <= ST_FETCH;
                     dst_q   <= dec.dst;
                     addr_q  <= addr_in;
                     lane_q  <= lane_in;
                     got_mem <= 1'b0;
                     got_vec <= 1'b0;
                  end else begin
                     illegal_q <= 1'b1;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_fire) begin
                  word_q  <= mem_rd_data;
                  got_mem <= 1'b1;
               end
               if (vec_fire) begin
                  vec_q   <= vrd_data;
                  got_vec <= 1'b1;
               end
               if (both_in) begin
                  state <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (vwr_ack) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign issue_ready  = (state == ST_IDLE);
   assign busy         = (state != ST_IDLE);
   assign done         = done_q;
   assign illegal      = illegal_q;
   assign mem_rd_valid = (state == ST_FETCH) && !got_mem;
   assign mem_rd_addr  = addr_q;
   assign vrd_req      = (state == ST_FETCH) && !got_vec;
   assign vrd_idx      = dst_q;
   assign vwr_req      = (state == ST_WRITE);
   assign vwr_idx      = dst_q;

endmodule

// File: rtl/vec_word_load_unit.sv
module vec_word_load_unit
   import vwl_pkg::*;
#(
   parameter int GPR_W      = 64,
   parameter int ADDR_W     = 32,
   parameter int LANE_W     = 32,
   parameter int LANES      = 4,
   parameter int NARROW_OPC = 31,
   parameter int NARROW_XO  = 71,
   parameter int WIDE_OPC   = 4,
   parameter int WIDE_XO    = 8,
   localparam int VEC_W     = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   output logic              issue_ready,
   input  logic [31:0]       issue_instr,
   input  logic [GPR_W-1:0]  base_val,
   input  logic [GPR_W-1:0]  index_val,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [LANE_W-1:0] mem_rd_data,
   output logic              vrd_req,
   input  logic              vrd_ack,
   output logic [6:0]        vrd_idx,
   input  logic [VEC_W-1:0]  vrd_data,
   output logic              vwr_req,
   input  logic              vwr_ack,
   output logic [6:0]        vwr_idx,
   output logic [VEC_W-1:0]  vwr_data
);

   localparam int LSEL_W = $clog2(LANES);
   localparam int BOFF_W = $clog2(LANE_W / 8);

   generate
      if ((LANE_W % 8) != 0 || LANE_W < 16) begin : g_bad_lane
         $error("LANE_W must be a multiple of 8 and at least 16");
      end
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two, at least 2");
      end
      if (ADDR_W > GPR_W || ADDR_W < LSEL_W + BOFF_W) begin : g_bad_addr
         $error("ADDR_W must fit in GPR_W and cover the lane select");
      end
      if (VIDX_W != 7) begin : g_bad_idx
         $error("register index width must be 7");
      end
   endgenerate

   vwl_dec_t          dec;
   logic [ADDR_W-1:0] addr_w;
   logic [LSEL_W-1:0] lane_w;
   logic [LANE_W-1:0] word_q;
   logic [VEC_W-1:0]  vec_q;
   logic [LSEL_W-1:0] lane_q;

   vwl_decode #(
      .NARROW_OPC (NARROW_OPC),
      .NARROW_XO  (NARROW_XO),
      .WIDE_OPC   (WIDE_OPC),
      .WIDE_XO    (WIDE_XO)
   ) u_decode (
      .instr (issue_instr),
      .dec   (dec)
   );

   vwl_agu #(
      .GPR_W  (GPR_W),
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_agu (
      .base_val     (base_val),
      .index_val    (index_val),
      .base_zero    (dec.base_zero),
      .addr_aligned (addr_w),
      .lane         (lane_w)
   );

   vwl_ctrl #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_valid  (issue_valid),
      .issue_ready  (issue_ready),
      .dec          (dec),
      .addr_in      (addr_w),
      .lane_in      (lane_w),
      .busy         (busy),
      .done         (done),
      .illegal      (illegal),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_ready (mem_rd_ready),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_data  (mem_rd_data),
      .vrd_req      (vrd_req),
      .vrd_ack      (vrd_ack),
      .vrd_idx      (vrd_idx),
      .vrd_data     (vrd_data),
      .vwr_req      (vwr_req),
      .vwr_ack      (vwr_ack),
      .vwr_idx      (vwr_idx),
      .word_q       (word_q),
      .vec_q        (vec_q),
      .lane_q       (lane_q)
   );

   vwl_merge #(
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_merge (
      .old_vec  (vec_q),
      .bus_word (word_q),
      .lane     (lane_q),
      .new_vec  (vwr_data)
   );

endmodule

// File: rtl/vwl_unit_chk.sv
module vwl_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int VEC_W  = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              illegal,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              vrd_req,
   input logic              vrd_ack,
   input logic [6:0]        vrd_idx,
   input logic              vwr_req,
   input logic              vwr_ack,
   input logic [6:0]        vwr_idx,
   input logic [VEC_W-1:0]  vwr_data
);

   // R8
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_rd_valid && !vrd_req && !vwr_req));

   // R10
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R10
   vrd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vrd_req && !vrd_ack) |=> (vrd_req && $stable(vrd_idx)));

   // R7
   rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vrd_req && vwr_req));

   // R7
   vwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vwr_req && !vwr_ack) |=> (vwr_req && $stable(vwr_idx) && $stable(vwr_data)));

   // R9
   commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vwr_req && vwr_ack) |=> (done && !busy));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vwr_req |-> busy);

endmodule

bind vec_word_load_unit vwl_unit_chk #(
   .ADDR_W (ADDR_W),
   .VEC_W  (VEC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .illegal      (illegal),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_ready (mem_rd_ready),
   .mem_rd_addr  (mem_rd_addr),
   .vrd_req      (vrd_req),
   .vrd_ack      (vrd_ack),
   .vrd_idx      (vrd_idx),
   .vwr_req      (vwr_req),
   .vwr_ack      (vwr_ack),
   .vwr_idx      (vwr_idx),
   .vwr_data     (vwr_data)
);

// File: tb/vec_word_load_unit_bench.sv
module vec_word_load_unit_bench;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue_valid = 1'b0;
   logic         issue_ready;
   logic [31:0]  issue_instr = '0;
   logic [63:0]  base_val = '0;
   logic [63:0]  index_val = '0;
   logic         busy, done, illegal;
   logic         mem_rd_valid;
   logic         mem_rd_ready = 1'b0;
   logic [31:0]  mem_rd_addr;
   logic [31:0]  mem_rd_data = '0;
   logic         vrd_req;
   logic         vrd_ack = 1'b0;
   logic [6:0]   vrd_idx;
   logic [127:0] vrd_data = '0;
   logic         vwr_req;
   logic         vwr_ack = 1'b0;
   logic [6:0]   vwr_idx;
   logic [127:0] vwr_data;

   int checks = 0;
   int failures = 0;
   int cycle = 0;
   logic [127:0] vrf [128];

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_word_load_unit u_vec_word_load_unit (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_instr(issue_instr), .base_val(base_val), .index_val(index_val),
      .busy(busy), .done(done), .illegal(illegal),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .vrd_req(vrd_req), .vrd_ack(vrd_ack), .vrd_idx(vrd_idx), .vrd_data(vrd_data),
      .vwr_req(vwr_req), .vwr_ack(vwr_ack), .vwr_idx(vwr_idx), .vwr_data(vwr_data)
   );

   always @(posedge clk) cycle <= cycle + 1;

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5B;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] narrow_instr(input logic [4:0] d, input logic [4:0] ra,
                                                input logic rc);
      // primary 31, extended 71 in bits [10:1]
      return {6'd31, d, ra, 5'd9, 10'd71, rc};
   endfunction

   function automatic logic [31:0] wide_instr(input logic [6:0] d, input logic [4:0] ra);
      // primary 4, extended 8 in bits [10:4], high dest bits [3:2]
      return {6'd4, d[4:0], ra, 5'd11, 7'd8, d[6:5], 2'b11};
   endfunction

   task automatic run_load(input string name, input logic [31:0] instr,
                           input logic [63:0] bv, input logic [63:0] iv,
                           input logic [6:0] exp_dst,
                           input int mdel, input int vdel, input int wdel,
                           input bit want_same);
      logic [63:0]  base_eff;
      logic [31:0]  ea;
      logic [31:0]  exp_addr;
      logic [31:0]  word;
      logic [127:0] exp_vec;
      int mcnt = 0, vcnt = 0, wcnt = 0;
      int mcyc = -1, vcyc = -2;
      int writes = 0;
      bit ready_bad = 0, fin = 0, pending = 0, done_early = 0;
      logic [31:0]  seen_addr = '0;
      logic [6:0]   seen_ridx = '0, seen_widx = '0;
      logic [127:0] seen_wdata = '0;

      base_eff = (instr[20:16] == 5'd0) ? 64'd0 : bv;
      ea       = 32'(base_eff + iv);
      exp_addr = {ea[31:2], 2'b00};
      word     = {mbyte(exp_addr), mbyte(exp_addr + 1), mbyte(exp_addr + 2), mbyte(exp_addr + 3)};
      exp_vec  = vrf[exp_dst];
      exp_vec[127 - 32*ea[3:2] -: 32] = word;

      @(negedge clk);
      issue_instr = instr; base_val = bv; index_val = iv; issue_valid = 1'b1;
      check("R9", {name, " ready before issue"}, {127'd0, issue_ready}, 128'd1);
      @(negedge clk);
      issue_valid = 1'b0;
      for (int n = 0; n < 60 && !fin; n++) begin
         if (pending) begin
            check("R9", {name, " done after commit"}, {126'd0, done, busy}, 128'd2);
            fin = 1;
            vwr_ack = 1'b0;
         end else begin
            if (done) done_early = 1;
            if (issue_ready) ready_bad = 1;
            mem_rd_ready = 1'b0;
            vrd_ack = 1'b0;
            vwr_ack = 1'b0;
            if (mem_rd_valid) begin
               if (mcnt >= mdel) begin
                  mem_rd_ready = 1'b1;
                  seen_addr = mem_rd_addr;
                  for (int k = 0; k < 4; k++) mem_rd_data[8*k +: 8] = mbyte(mem_rd_addr + 32'(k));
                  mcyc = n;
               end
               mcnt++;
            end
            if (vrd_req) begin
               if (vcnt >= vdel) begin
                  vrd_ack = 1'b1;
                  seen_ridx = vrd_idx;
                  vrd_data = vrf[vrd_idx];
                  vcyc = n;
               end
               vcnt++;
            end
            if (vwr_req) begin
               if (wcnt >= wdel) begin
                  vwr_ack = 1'b1;
                  seen_widx = vwr_idx;
                  seen_wdata = vwr_data;
                  writes++;
                  pending = 1;
               end
               wcnt++;
            end
         end
         @(negedge clk);
      end
      mem_rd_ready = 1'b0; vrd_ack = 1'b0; vwr_ack = 1'b0;
      if (pending) vrf[seen_widx] = seen_wdata;
      check("R9", {name, " finished"}, {127'd0, fin}, 128'd1);
      check("R9", {name, " ready low while busy"}, {127'd0, ready_bad}, 128'd0);
      check("R9", {name, " no early done"}, {127'd0, done_early}, 128'd0);
      check("R4", {name, " memory address"}, {96'd0, seen_addr}, {96'd0, exp_addr});
      check("R7", {name, " read index"}, {121'd0, seen_ridx}, {121'd0, exp_dst});
      check("R1", {name, " write index"}, {121'd0, seen_widx}, {121'd0, exp_dst});
      check("R5", {name, " merged vector"}, seen_wdata, exp_vec);
      check("R9", {name, " single write"}, 128'(writes), 128'd1);
      if (want_same)
         check("R10", {name, " same-cycle responses"}, 128'(mcyc == vcyc), 128'd1);
   endtask

   task automatic run_illegal(input string name, input logic [31:0] instr);
      bit quiet = 1;
      @(negedge clk);
      issue_instr = instr; base_val = 64'h40; index_val = 64'h4; issue_valid = 1'b1;
      @(negedge clk);
      issue_valid = 1'b0;
      check("R8", {name, " illegal pulse"}, {127'd0, illegal}, 128'd1);
      check("R8", {name, " still ready"}, {126'd0, issue_ready, busy}, 128'd2);
      for (int n = 0; n < 4; n++) begin
         if (mem_rd_valid || vrd_req || vwr_req || busy) quiet = 0;
         @(negedge clk);
         if (n == 0)
            check("R8", {name, " pulse one cycle"}, {127'd0, illegal}, 128'd0);
      end
      check("R8", {name, " no access"}, {127'd0, quiet}, 128'd1);
   endtask

   task automatic test_reset();
      check("R9", "reset outputs",
            {121'd0, busy, done, illegal, mem_rd_valid, vrd_req, vwr_req, issue_ready},
            128'd1);
   endtask

   task automatic test_narrow();
      // R1 R5: base 0x1000 + 0x24 -> lane 1
      run_load("narrow basic", narrow_instr(5'd5, 5'd3, 1'b0),
               64'h1000, 64'h24, 7'd5, 1, 0, 0, 0);
      // R1: record bit set is ignored, lane 0
      run_load("narrow rc set", narrow_instr(5'd31, 5'd2, 1'b1),
               64'h3000, 64'h1, 7'd31, 0, 0, 1, 0);
   endtask

   task automatic test_base_zero();
      // R3: base field 0 with nonzero base value; lane 3, low bits dropped (R4)
      run_load("base zero", narrow_instr(5'd9, 5'd0, 1'b0),
               64'hDEAD_0000_DEAD_0000, 64'h200F, 7'd9, 0, 1, 0, 0);
   endtask

   task automatic test_wide();
      // R2: dest 0x5A, upper sum bits truncated (R4), lane 2
      run_load("wide upper", wide_instr(7'h5A, 5'd7),
               64'h1234_5678_0000_0100, 64'h8, 7'h5A, 0, 0, 0, 0);
      // R2: dest 127, 32-bit wrap of the sum, lane 1
      run_load("wide wrap", wide_instr(7'd127, 5'd4),
               64'hFFFF_FFF0, 64'h14, 7'd127, 2, 1, 0, 0);
   endtask

   task automatic test_overlap();
      // R10: same-cycle, memory-first and register-first responses
      run_load("both same", narrow_instr(5'd12, 5'd1, 1'b0),
               64'h8000, 64'h38, 7'd12, 2, 2, 2, 1);
      run_load("mem first", wide_instr(7'd64, 5'd1),
               64'h8800, 64'h4, 7'd64, 0, 3, 0, 0);
      run_load("reg first", wide_instr(7'd64, 5'd1),
               64'h9000, 64'hC, 7'd64, 3, 0, 1, 0);
   endtask

   task automatic test_byte_order();
      // R6 R7: lane 1 then lane 2 of the same register, earlier lane kept
      run_load("order a", narrow_instr(5'd20, 5'd6, 1'b0),
               64'hABCD_0000, 64'h0104, 7'd20, 0, 0, 0, 0);
      run_load("order b", narrow_instr(5'd20, 5'd6, 1'b0),
               64'hABCD_0000, 64'h0208, 7'd20, 1, 1, 0, 0);
   endtask

   task automatic test_illegal();
      run_illegal("bad ext narrow", {6'd31, 5'd1, 5'd1, 5'd2, 10'd70, 1'b0});
      run_illegal("bad ext wide", {6'd4, 5'd1, 5'd1, 5'd2, 7'd9, 4'b0011});
      run_illegal("bad primary", {6'd5, 5'd1, 5'd1, 5'd2, 10'd71, 1'b0});
   endtask

   initial begin
      for (int i = 0; i < 128; i++)
         vrf[i] = {32'h1000_0000 + 32'(i), 32'h2000_0000 + 32'(i),
                   32'h3000_0000 + 32'(i), 32'h4000_0000 + 32'(i)};
      repeat (3) @(posedge clk);
      @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_narrow();
      test_base_zero();
      test_wide();
      test_overlap();
      test_byte_order();
      test_illegal();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule